// File: doc/BRIEF.md
# Non-destructive memory size probe

This block is a small bus-master engine that finds out, after power-up, whether a RAM region is fitted and how many bytes it holds. It drives a simple word-wide memory port with a request strobe, write enable, byte address, write data, read data and read-valid. A single start pulse launches a run. The largest size to search is a port. When the run ends, the engine raises a one-cycle done pulse together with a present flag and the detected size in bytes.

The region must be a power of two in size and must alias its addresses modulo that size. The engine saves the first two words of the region. It then checks that word 0 holds two complementary patterns. After that it tries byte offsets 4, 8, 16 and so on. At each offset it writes the complement of the word found there into word 0 and compares word 0 with the offset. When the two read back equal, the address has wrapped, and that offset is the size. Only words 0 and 1 are ever written, and both get their saved contents back before done. Higher addresses, which may hold battery-backed data, are only read.

Top module: `mem_size_probe`

## Requirements
- R1: After reset, `done`, `memReq`, `present` and `sizeBytes` are all 0.
- R2: A run begins with two reads, first byte address 0 and then byte address 4. Its last two writes put the saved word 0 back at address 0 and then the saved word 1 at address 4. `done` rises in the cycle after the second of these restore writes.
- R3: The presence check has two rounds. The first writes 0x5555AAAA to address 0 and 0xAAAA5555 to address 4, then reads address 0. The second round does the same with the two patterns swapped. If address 0 does not read back its pattern in either round, the run reports `present`=0 and `sizeBytes`=0.
- R4: Sizing tries offsets starting at 4 and doubling each time. At each offset the engine reads the word there, writes its bitwise complement to address 0, then reads address 0 and the offset. The first offset at which the two reads are equal is reported as `sizeBytes`, with `present`=1.
- R5: If the offset reaches `maxSize` without a wrap, the run reports `sizeBytes`=`maxSize` and `present`=1. `maxSize` must be a power of two of at least 8.
- R6: Every write the engine issues goes to byte address 0 or byte address 4.
- R7: At most one read is outstanding. No request is issued while a read has not yet returned `memRvalid`.
- R8: `done` is high for exactly one cycle per run. `present` and `sizeBytes` keep their values after `done` until the next run is started.
- R9: A `start` pulse during a run is ignored. The run completes with one `done` and the same result as an undisturbed run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that launches a run when idle |
| maxSize | input | AW+1 | Largest size to search, in bytes (power of two) |
| memReq | output | 1 | Memory request strobe, one cycle per transaction |
| memWe | output | 1 | Write enable qualifying `memReq` |
| memAddr | output | AW | Byte address of the transaction |
| memWdata | output | DW | Write data |
| memRdata | input | DW | Read data, valid with `memRvalid` |
| memRvalid | input | 1 | Read data valid, one pulse per read |
| done | output | 1 | One-cycle pulse at the end of a run |
| present | output | 1 | Memory detected in the last run |
| sizeBytes | output | AW+1 | Size detected in the last run, in bytes |

## Verification
The time to a result depends on the memory's read latency and on how many offsets are tried. The bench therefore does not count a fixed number of cycles after `start`. It samples `done` on every falling edge and reads `present` and `sizeBytes` in the same half-cycle in which `done` is seen. It then watches three more falling edges to confirm that `done` dropped after one cycle and that the results held. A bus monitor on the rising edges, where the memory model also acts, logs each run's first two transactions and last two writes for the ordering checks. It also counts any write above address 4 and any request issued while a read is still outstanding.

// File: rtl/probe_pkg.sv
package probe_pkg;

  typedef enum logic [1:0] {
    SEL_W0  = 2'd0,
    SEL_W1  = 2'd1,
    SEL_OFS = 2'd2
  } addrSel_e;

  typedef enum logic [2:0] {
    WD_PAT_A = 3'd0,
    WD_PAT_B = 3'd1,
    WD_NOT_T = 3'd2,
    WD_SAVE0 = 3'd3,
    WD_SAVE1 = 3'd4
  } wdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     req;
    logic     we;
    addrSel_e addrSel;
    wdSel_e   wdSel;
    logic     capSave0;
    logic     capSave1;
    logic     capT;
    logic     capA;
    logic     initOfs;
    logic     stepOfs;
    logic     clrRes;
    logic     setZero;
    logic     setMax;
    logic     setOfs;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic matchA;
    logic matchB;
    logic wrapHit;
    logic ofsAtMax;
  } status_t;

endpackage

// File: rtl/probe_ctrl.sv
module probe_ctrl
  import probe_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    memRvalid,
  input  status_t stat,
  output strobe_t stb,
  output logic    done
);

  typedef enum logic [4:0] {
    S_IDLE, S_RD_S0, S_WT_S0, S_RD_S1, S_WT_S1,
    S_WR_P0, S_WR_P1, S_RD_CK, S_WT_CK, S_LOOP,
    S_RD_T, S_WT_T, S_WR_C, S_RD_A, S_WT_A,
    S_RD_B, S_WT_B, S_WR_R0, S_WR_R1, S_DONE
  } state_e;

  state_e stateQ, stateD;
  logic   phaseQ, phaseD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      phaseQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      phaseQ <= phaseD;
    end
  end

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    phaseD = phaseQ;
    unique case (stateQ)
      S_IDLE: begin
        if (start) begin
          stb.clrRes = 1'b1;
          phaseD     = 1'b0;
          stateD     = S_RD_S0;
        end
      end
      S_RD_S0: begin
        stb.req = 1'b1; stb.addrSel = SEL_W0;
        stateD  = S_WT_S0;
      end
      S_WT_S0: begin
        if (memRvalid) begin
          stb.capSave0 = 1'b1;
          stateD       = S_RD_S1;
        end
      end
      S_RD_S1: begin
        stb.req = 1'b1; stb.addrSel = SEL_W1;
        stateD  = S_WT_S1;
      end
      S_WT_S1: begin
        if (memRvalid) begin
          stb.capSave1 = 1'b1;
          stateD       = S_WR_P0;
        end
      end
      S_WR_P0: begin
        stb.req = 1'b1; stb.we = 1'b1; stb.addrSel = SEL_W0;
        stb.wdSel = phaseQ ? WD_PAT_B : WD_PAT_A;
        stateD    = S_WR_P1;
      end
      S_WR_P1: begin
        stb.req = 1'b1; stb.we = 1'b1; stb.addrSel = SEL_W1;
        stb.wdSel = phaseQ ? WD_PAT_A : WD_PAT_B;
        stateD    = S_RD_CK;
      end
      S_RD_CK: begin
        stb.req = 1'b1; stb.addrSel = SEL_W0;
        stateD  = S_WT_CK;
      end
      S_WT_CK: begin
        if (memRvalid) begin
          if (!(phaseQ ? stat.matchB : stat.matchA)) begin
            stb.setZero = 1'b1;
            stateD      = S_WR_R0;
          end else if (!phaseQ) begin
            phaseD = 1'b1;
            stateD = S_WR_P0;
          end else begin
            stb.initOfs = 1'b1;
            stateD      = S_LOOP;
          end
        end
      end
      S_LOOP: begin
        if (stat.ofsAtMax) begin
          stb.setMax = 1'b1;
          stateD     = S_WR_R0;
        end else begin
          stateD = S_RD_T;
        end
      end
      S_RD_T: begin
        stb.req = 1'b1; stb.addrSel = SEL_OFS;
        stateD  = S_WT_T;
      end
      S_WT_T: begin
        if (memRvalid) begin
          stb.capT = 1'b1;
          stateD   = S_WR_C;
        end
      end
      S_WR_C: begin
        stb.req = 1'b1; stb.we = 1'b1; stb.addrSel = SEL_W0;
        stb.wdSel = WD_NOT_T;
        stateD    = S_RD_A;
      end
      S_RD_A: begin
        stb.req = 1'b1; stb.addrSel = SEL_W0;
        stateD  = S_WT_A;
      end
      S_WT_A: begin
        if (memRvalid) begin
          stb.capA = 1'b1;
          stateD   = S_RD_B;
        end
      end
      S_RD_B: begin
        stb.req = 1'b1; stb.addrSel = SEL_OFS;
        stateD  = S_WT_B;
      end
      S_WT_B: begin
        if (memRvalid) begin
          if (stat.wrapHit) begin
            stb.setOfs = 1'b1;
            stateD     = S_WR_R0;
          end else begin
            stb.stepOfs = 1'b1;
            stateD      = S_LOOP;
          end
        end
      end
      S_WR_R0: begin
        stb.req = 1'b1; stb.we = 1'b1; stb.addrSel = SEL_W0;
        stb.wdSel = WD_SAVE0;
        stateD    = S_WR_R1;
      end
      S_WR_R1: begin
        stb.req = 1'b1; stb.we = 1'b1; stb.addrSel = SEL_W1;
        stb.wdSel = WD_SAVE1;
        stateD    = S_DONE;
      end
      S_DONE: stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= (stateD == S_DONE);
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_START_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != S_IDLE) |=> !(stb.clrRes && $past(stb.req)) ); // R9

endmodule

// File: rtl/probe_dp.sv
module probe_dp
  import probe_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [AW:0]   maxSize,
  input  logic [DW-1:0] memRdata,
  output status_t       stat,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          present,
  output logic [AW:0]   sizeBytes
);

  localparam int SW         = AW + 1;
  localparam int WORD_BYTES = DW / 8;
  localparam int REPS       = DW / 32;
  localparam logic [DW-1:0] PAT_A = {REPS{32'h5555AAAA}};
  localparam logic [DW-1:0] PAT_B = {REPS{32'hAAAA5555}};

  logic [DW-1:0] save0Q, save1Q, tQ, aQ;
  logic [SW-1:0] ofsQ;

  // captured words
  always_ff @(posedge clk) begin
    if (!rstN) begin
      save0Q <= '0;
      save1Q <= '0;
      tQ     <= '0;
      aQ     <= '0;
    end else begin
      if (stb.capSave0) save0Q <= memRdata;
      if (stb.capSave1) save1Q <= memRdata;
      if (stb.capT)     tQ     <= memRdata;
      if (stb.capA)     aQ     <= memRdata;
    end
  end

  // probe offset
  always_ff @(posedge clk) begin
    if (!rstN)            ofsQ <= '0;
    else if (stb.initOfs) ofsQ <= SW'(WORD_BYTES);
    else if (stb.stepOfs) ofsQ <= ofsQ << 1;
  end

  // results
  always_ff @(posedge clk) begin
    if (!rstN || stb.clrRes || stb.setZero) begin
      present   <= 1'b0;
      sizeBytes <= '0;
    end else if (stb.setMax) begin
      present   <= 1'b1;
      sizeBytes <= maxSize;
    end else if (stb.setOfs) begin
      present   <= 1'b1;
      sizeBytes <= ofsQ;
    end
  end

  // bus outputs
  assign memReq = stb.req;
  assign memWe  = stb.we;

  always_comb begin
    unique case (stb.addrSel)
      SEL_W0:  memAddr = '0;
      SEL_W1:  memAddr = AW'(WORD_BYTES);
      SEL_OFS: memAddr = ofsQ[AW-1:0];
      default: memAddr = '0;
    endcase
  end

  always_comb begin
    unique case (stb.wdSel)
      WD_PAT_A: memWdata = PAT_A;
      WD_PAT_B: memWdata = PAT_B;
      WD_NOT_T: memWdata = ~tQ;
      WD_SAVE0: memWdata = save0Q;
      WD_SAVE1: memWdata = save1Q;
      default:  memWdata = '0;
    endcase
  end

  // status
  assign stat.matchA   = (memRdata == PAT_A);
  assign stat.matchB   = (memRdata == PAT_B);
  assign stat.wrapHit  = (memRdata == aQ);
  assign stat.ofsAtMax = (ofsQ >= maxSize);

  AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !present |-> (sizeBytes == '0)); // R3

  AST_SIZE_POW2: assert property (@(posedge clk) disable iff (!rstN)
    present |-> ($countones(sizeBytes) == 1)); // R4

  AST_SIZE_FROM_OFS: assert property (@(posedge clk) disable iff (!rstN)
    stb.setOfs |=> (sizeBytes == $past(ofsQ))); // R4

endmodule

// File: rtl/mem_size_probe.sv
module mem_size_probe
  import probe_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW:0]   maxSize,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  input  logic          memRvalid,
  output logic          done,
  output logic          present,
  output logic [AW:0]   sizeBytes
);

  localparam int WORD_BYTES = DW / 8;

  strobe_t stb;
  status_t stat;

  probe_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .memRvalid (memRvalid),
    .stat      (stat),
    .stb       (stb),
    .done      (done)
  );

  probe_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .maxSize   (maxSize),
    .memRdata  (memRdata),
    .stat      (stat),
    .memReq    (memReq),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .present   (present),
    .sizeBytes (sizeBytes)
  );

  // outstanding-read tracker for the bus assertions
  logic readPend;
  always_ff @(posedge clk) begin
    if (!rstN)                 readPend <= 1'b0;
    else if (memReq && !memWe) readPend <= 1'b1;
    else if (memRvalid)        readPend <= 1'b0;
  end

  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !readPend); // R7

  AST_WRITE_LOW_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memAddr == '0 || memAddr == AW'(WORD_BYTES))); // R6

  AST_RESTORE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(memReq && memWe && memAddr == AW'(WORD_BYTES))
                 && $past(memReq && memWe && memAddr == '0, 2))); // R2

  AST_IDLE_AT_RESET: assert property (@(posedge clk)
    $rose(rstN) |-> (!done && !memReq && !present)); // R1

endmodule

// File: tb/sim_mem_size_probe.sv
module sim_mem_size_probe;

  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int WORDS = 2048;
  localparam int NV    = 7;

  // vector table: real size (0 = absent), stuck bit0 in word 0, maxSize, exp present, exp size
  localparam int V_REAL [NV] = '{0,    4096, 8192, 8,    1024, 8192, 256};
  localparam int V_STK  [NV] = '{0,    0,    0,    0,    1,    0,    0};
  localparam int V_MAX  [NV] = '{8192, 8192, 8192, 8192, 8192, 2048, 8192};
  localparam int V_PRES [NV] = '{0,    1,    1,    1,    0,    1,    1};
  localparam int V_SIZE [NV] = '{0,    4096, 8192, 8,    0,    2048, 256};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW:0]   maxSize = '0;
  logic          memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata = '0;
  logic          memRvalid = 1'b0;
  logic          done, present;
  logic [AW:0]   sizeBytes;

  always #2.5 clk = ~clk;

  mem_size_probe #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .maxSize(maxSize),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memRvalid(memRvalid),
    .done(done), .present(present), .sizeBytes(sizeBytes)
  );

  int nChk = 0;
  int nErr = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory with aliasing
  logic [DW-1:0] mem [WORDS];
  int            realSize = 0;
  bit            stuck = 1'b0;
  logic [DW-1:0] lastBus = '0;
  logic          p1v = 1'b0;
  logic [DW-1:0] p1d = '0;

  // bus monitor state
  int            opCnt = 0;
  logic          fWe [2];
  logic [AW-1:0] fAddr [2];
  logic [AW-1:0] lwA0, lwA1;
  logic [DW-1:0] lwD0, lwD1;
  int            badW = 0;
  int            overlap = 0;
  bit            pend = 1'b0;

  function automatic int widx(input logic [AW-1:0] a);
    return (int'(a) >> 2) & (realSize / 4 - 1);
  endfunction

  always @(posedge clk) begin
    if (memRvalid) pend = 1'b0;
    memRvalid <= p1v;
    memRdata  <= p1d;
    p1v       <= 1'b0;
    if (rstN && memReq) begin
      if (pend) overlap++;
      if (opCnt < 2) begin
        fWe[opCnt]   = memWe;
        fAddr[opCnt] = memAddr;
      end
      opCnt++;
      if (memWe) begin
        if (memAddr > 16'd4) badW++;
        lwA0 = lwA1; lwD0 = lwD1;
        lwA1 = memAddr; lwD1 = memWdata;
        if (realSize > 0) mem[widx(memAddr)] = memWdata;
        lastBus = memWdata;
      end else begin
        pend = 1'b1;
        p1v <= 1'b1;
        if (realSize == 0) begin
          p1d <= lastBus;
        end else begin
          logic [DW-1:0] rd;
          rd = mem[widx(memAddr)];
          if (stuck && widx(memAddr) == 0) rd[0] = 1'b0;
          p1d <= rd;
          lastBus = rd;
        end
      end
    end
  end

  int cyc = 0;
  bit hung = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !hung) hung = 1'b1;
  end

  task automatic runVec(input int vi, input bit midStart);
    logic [DW-1:0] s0, s1;
    int            t;
    int            dones;
    bit            gotDone;
    string         tag;
    tag = $sformatf("vec%0d", vi);
    realSize = V_REAL[vi];
    stuck    = V_STK[vi] != 0;
    for (int i = 0; i < WORDS; i++) mem[i] = 32'h3C00_0000 + i * 32'h0001_0102 + vi;
    s0 = {mem[0][DW-1:1], 1'b0};
    mem[0] = s0;
    s1 = mem[1];
    opCnt = 0; badW = 0; overlap = 0;
    @(negedge clk);
    maxSize = (AW+1)'(V_MAX[vi]);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0; gotDone = 1'b0;
    while (!gotDone && t < 20000 && !hung) begin
      if (midStart && t == 10) start = 1'b1;
      else start = 1'b0;
      if (done) gotDone = 1'b1;
      else begin @(negedge clk); t++; end
    end
    start = 1'b0;
    check(gotDone, {"R2 done reached ", tag}, gotDone, 1);
    // R3 R4 R5: result at done
    check(present == V_PRES[vi][0], {"R3/R4/R5 present ", tag}, present, V_PRES[vi]);
    check(sizeBytes == (AW+1)'(V_SIZE[vi]), {"R4/R5 size ", tag}, sizeBytes, V_SIZE[vi]);
    // R2: first two ops are reads of 0 then 4; last two writes restore
    check(fWe[0] == 1'b0 && fAddr[0] == 0 && fWe[1] == 1'b0 && fAddr[1] == 4,
          {"R2 save reads ", tag}, {fAddr[0], fAddr[1]}, 32'h0000_0004);
    check(lwA0 == 0 && lwA1 == 4, {"R2 restore order ", tag}, {lwA0, lwA1}, 32'h0000_0004);
    if (realSize > 0) begin
      check(mem[0] == s0, {"R2 word0 kept ", tag}, mem[0], s0);
      check(mem[1] == s1, {"R2 word1 kept ", tag}, mem[1], s1);
    end
    check(badW == 0, {"R6 high writes ", tag}, badW, 0);
    check(overlap == 0, {"R7 overlap ", tag}, overlap, 0);
    // R8: single pulse, results held
    dones = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check(dones == 1, {"R8 done pulses ", tag}, dones, 1);
    check(present == V_PRES[vi][0] && sizeBytes == (AW+1)'(V_SIZE[vi]),
          {"R8 held ", tag}, sizeBytes, V_SIZE[vi]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && !memReq && !present && sizeBytes == 0, "R1 reset outputs",
          {done, memReq, present}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !memReq && !present && sizeBytes == 0, "R1 idle after reset",
          {done, memReq, present}, 0);
    for (int v = 0; v < NV; v++) runVec(v, 1'b0);
    // R9: start pulse while busy is ignored
    runVec(1, 1'b1);
    runVec(6, 1'b1);
    if (hung) check(1'b0, "watchdog", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    #1000000;
    nChk++; nErr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

endmodule